// File: doc/BRIEF.md
# Page Write Commit Engine

This block sits behind a serial memory front end and turns the write-type transactions that the front end has already framed into committed array and status updates. The front end hands over a strobe for the opcode byte, a strobe for the decoded array address, a strobe for each complete data byte, and a pulse when chip select is released. That release pulse comes with a flag that says whether it fell on a byte boundary. The engine keeps the write-enable latch and loads up to one page of data bytes into a local buffer. It decides at chip-select release whether the transaction may commit. An accepted write then starts a self-timed busy period, counted in system clocks. At the end of that period the buffered bytes go out on the array write port, one per clock, and the status bits are updated.

A protection block outside the engine supplies two verdicts. One says whether the page at `page_base_o` is locked. The other says whether status writes are currently blocked. The engine samples both at chip-select release. Read traffic is not handled here.

The capture side is a state machine with these states:
- CAP_IDLE: waits for an opcode.
- CAP_LATCH: a latch opcode has arrived.
- CAP_ADDR: waits for the address.
- CAP_EMPTY: the address has arrived but no data yet.
- CAP_FILL: data is being loaded.
- CAP_SR_WAIT and CAP_SR_HAVE: a status write, before and after its data byte.
- CAP_DROP: the transaction will be discarded.

Its transitions are:
- Opcode decode leaves CAP_IDLE.
- An extra byte after a latch opcode leads to CAP_DROP.
- The address strobe moves CAP_ADDR to CAP_EMPTY.
- The first data byte moves CAP_EMPTY to CAP_FILL, or CAP_SR_WAIT to CAP_SR_HAVE.
- Any opcode while busy leads to CAP_DROP.
- Chip-select release returns every state to CAP_IDLE. It commits only from CAP_LATCH, CAP_FILL or CAP_SR_HAVE.

The commit side is a second state machine:
- SEQ_IDLE: waits for an accepted commit.
- SEQ_TIMING: runs the busy timer.
- SEQ_FLUSH: streams the buffered bytes to the array.
- SEQ_RETIRE: clears the latch and loads the status bits.

It moves from SEQ_IDLE to SEQ_TIMING on an accepted commit. At timer expiry it goes to SEQ_FLUSH for an array write, or straight to SEQ_RETIRE for a status write. After the last slot of SEQ_FLUSH it goes to SEQ_RETIRE, and SEQ_RETIRE always returns to SEQ_IDLE.

Top module: `page_commit_engine`

## Requirements
- R1: After reset the block is not busy, the write-enable latch is 0, `status_o` reads 0x00 and no array write is issued.
- R2: Opcode byte 0x06 sets the write-enable latch, and opcode byte 0x04 clears it. Either takes effect only when chip select is released on a byte boundary with no byte or address strobe after the opcode. The latch is visible as `wel_o` and as bit 1 of `status_o`.
- R3: If any data byte is strobed after opcode 0x06 before chip select is released, the latch is left unchanged.
- R4: An array write (opcode 0x02) or a status write (opcode 0x01) is accepted only while the write-enable latch is 1. Otherwise no busy period starts.
- R5: A write is accepted only if chip select is released with `cs_aligned_i` high and at least one data byte has been loaded. Otherwise it is discarded and the latch keeps its value.
- R6: For an array write, the in-page offset comes from address bits [4:0] and the page base from bits [12:5]. Bytes fill successive offsets and wrap from 31 to 0 within the same page, so a later byte overwrites an earlier one. At commit, each loaded offset is written to the array once, in ascending offset order, at page base plus offset.
- R7: `busy_o` rises in the cycle after the release pulse. It stays high for WRITE_CYCLES+33 cycles for an array write and WRITE_CYCLES+1 cycles for a status write. No array write occurs during the first WRITE_CYCLES busy cycles.
- R8: While busy, `status_o` reads 0xFF. When idle it reads {protect-enable bit, 3'b000, block-protect bits [1:0], latch, 1'b0}.
- R9: The write-enable latch is 0 once the busy period of any accepted write ends.
- R10: A status write stores bits 7, 3 and 2 of its first data byte into status bits 7, 3 and 2. All other data bits and any further data bytes are dropped.
- R11: A locked page verdict at release rejects an array write. A blocked status verdict at release rejects a status write. In both cases the latch stays set.
- R12: Every command whose opcode arrives while busy is ignored. It changes neither the latch, the status bits, the page buffer nor the busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Opcode byte strobe, first byte of a transaction |
| op_byte_i | input | 8 | Opcode byte |
| addr_valid_i | input | 1 | Array address strobe |
| addr_i | input | ADDR_W | Array address |
| byte_valid_i | input | 1 | Strobe for each complete byte after the opcode or address |
| byte_i | input | 8 | Data byte |
| cs_rise_i | input | 1 | Chip-select release pulse |
| cs_aligned_i | input | 1 | Release fell on a byte boundary |
| page_locked_i | input | 1 | Protection verdict for the page at `page_base_o` |
| status_locked_i | input | 1 | Protection verdict for status writes |
| page_base_o | output | ADDR_W | Base address of the buffered page |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_wdata_o | output | 8 | Array write data |
| busy_o | output | 1 | Write cycle in progress |
| wel_o | output | 1 | Write-enable latch |
| status_o | output | 8 | Status byte as seen by a status read |

## Verification
The hardest situation to reach is a command that arrives while a commit is already running. It has to be a write that would otherwise succeed, because the latch is still set until the end of the busy period. The stimulus starts an array write and then, inside the timed window, issues a complete status write with an aligned release. It then checks that the status bits and the busy length are untouched. The page wrap is reached by starting two bytes before the page end and sending 34 bytes, so that both end slots are overwritten and the scoreboard expects the late values.

// File: rtl/pce_pkg.sv
package pce_pkg;
    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_WRDI  = 8'h04;
    localparam logic [7:0] OPC_WRSR  = 8'h01;
    localparam logic [7:0] OPC_WRITE = 8'h02;

    typedef enum logic [2:0] {
        CAP_IDLE,
        CAP_LATCH,
        CAP_ADDR,
        CAP_EMPTY,
        CAP_FILL,
        CAP_SR_WAIT,
        CAP_SR_HAVE,
        CAP_DROP
    } cap_state_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_TIMING,
        SEQ_FLUSH,
        SEQ_RETIRE
    } seq_state_t;

    typedef struct packed {
        logic       wpen;
        logic [1:0] bp;
    } sr_bits_t;
endpackage

// File: rtl/pce_page_buf.sv
module pce_page_buf #(
    parameter int ADDR_W     = 13,
    parameter int PAGE_BYTES = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load_i,
    input  logic [ADDR_W-1:0]                 load_addr_i,
    input  logic                              wr_i,
    input  logic [7:0]                        wr_data_i,
    input  logic [$clog2(PAGE_BYTES)-1:0]     rd_idx_i,
    output logic [7:0]                        rd_data_o,
    output logic                              rd_valid_o,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] base_o
);
    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int BASE_W = ADDR_W - OFS_W;

    logic [7:0]            mem_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;
    logic [OFS_W-1:0]      ptr_q;
    logic [BASE_W-1:0]     base_q;

    // write pointer: loaded from the address, then wraps inside the page
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            base_q <= '0;
        end else if (load_i) begin
            ptr_q  <= load_addr_i[OFS_W-1:0];
            base_q <= load_addr_i[ADDR_W-1:OFS_W];
        end else if (wr_i) begin
            ptr_q  <= ptr_q + 1'b1;
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
                vld_q[g] <= 1'b0;
            end else if (load_i) begin
                vld_q[g] <= 1'b0;
            end else if (wr_i && (ptr_q == OFS_W'(g))) begin
                mem_q[g] <= wr_data_i;
                vld_q[g] <= 1'b1;
            end
        end
    end

    assign rd_data_o  = mem_q[rd_idx_i];
    assign rd_valid_o = vld_q[rd_idx_i];
    assign base_o     = base_q;

    AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (vld_q == '0)); // R6
endmodule

// File: rtl/pce_capture.sv
module pce_capture
    import pce_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid_i,
    input  logic [7:0] op_byte_i,
    input  logic       addr_valid_i,
    input  logic       byte_valid_i,
    input  logic [7:0] byte_i,
    input  logic       cs_rise_i,
    input  logic       cs_aligned_i,
    input  logic       busy_i,
    input  logic       wel_i,
    input  logic       page_locked_i,
    input  logic       status_locked_i,
    output logic       buf_load_o,
    output logic       buf_wr_o,
    output logic       set_wel_o,
    output logic       clr_wel_o,
    output logic       go_array_o,
    output logic       go_status_o,
    output logic [7:0] sr_data_o
);
    cap_state_t state_q, state_d;
    logic       is_wren_q;
    logic [7:0] sr_data_q;
    logic       commit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_IDLE;
        else        state_q <= state_d;
    end

    // side registers: latch opcode kind and first status data byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_wren_q <= 1'b0;
            sr_data_q <= '0;
        end else begin
            if (state_q == CAP_IDLE && op_valid_i)
                is_wren_q <= (op_byte_i == OPC_WREN);
            if (state_q == CAP_SR_WAIT && byte_valid_i && !cs_rise_i)
                sr_data_q <= byte_i;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (cs_rise_i) begin
            state_d = CAP_IDLE;
        end else begin
            unique case (state_q)
                CAP_IDLE: begin
                    if (op_valid_i) begin
                        if (busy_i)
                            state_d = CAP_DROP;
                        else if (op_byte_i == OPC_WREN || op_byte_i == OPC_WRDI)
                            state_d = CAP_LATCH;
                        else if (op_byte_i == OPC_WRITE)
                            state_d = CAP_ADDR;
                        else if (op_byte_i == OPC_WRSR)
                            state_d = CAP_SR_WAIT;
                        else
                            state_d = CAP_DROP;
                    end
                end
                CAP_LATCH:   if (byte_valid_i || addr_valid_i) state_d = CAP_DROP;
                CAP_ADDR:    if (addr_valid_i) state_d = CAP_EMPTY;
                CAP_EMPTY:   if (byte_valid_i) state_d = CAP_FILL;
                CAP_SR_WAIT: if (byte_valid_i) state_d = CAP_SR_HAVE;
                CAP_FILL, CAP_SR_HAVE, CAP_DROP: state_d = state_q;
                default:     state_d = CAP_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        commit      = cs_rise_i && cs_aligned_i;
        buf_load_o  = addr_valid_i && !cs_rise_i && (state_q == CAP_ADDR);
        buf_wr_o    = byte_valid_i && !cs_rise_i &&
                      (state_q == CAP_EMPTY || state_q == CAP_FILL);
        set_wel_o   = commit && (state_q == CAP_LATCH) && is_wren_q;
        clr_wel_o   = commit && (state_q == CAP_LATCH) && !is_wren_q;
        go_array_o  = commit && (state_q == CAP_FILL) && wel_i && !page_locked_i;
        go_status_o = commit && (state_q == CAP_SR_HAVE) && wel_i && !status_locked_i;
        sr_data_o   = sr_data_q;
    end

    AST_GO_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (go_array_o || go_status_o) |-> wel_i); // R4
    AST_NO_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> !(go_array_o || go_status_o || set_wel_o || clr_wel_o)); // R12
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({go_array_o, go_status_o, set_wel_o, clr_wel_o})); // R5
endmodule

// File: rtl/pce_sequencer.sv
module pce_sequencer
    import pce_pkg::*;
#(
    parameter int PAGE_BYTES   = 32,
    parameter int WRITE_CYCLES = 2000000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          set_wel_i,
    input  logic                          clr_wel_i,
    input  logic                          go_array_i,
    input  logic                          go_status_i,
    input  logic [7:0]                    sr_data_i,
    input  logic                          rd_valid_i,
    output logic [$clog2(PAGE_BYTES)-1:0] rd_idx_o,
    output logic                          arr_we_o,
    output logic                          busy_o,
    output logic                          wel_o,
    output sr_bits_t                      sr_o
);
    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WRITE_CYCLES - 1);
    localparam logic [OFS_W-1:0] IDX_LAST = OFS_W'(PAGE_BYTES - 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [OFS_W-1:0] idx_q;
    logic             is_status_q;
    logic [7:0]       sr_data_q;
    logic             wel_q;
    sr_bits_t         sr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   if (go_array_i || go_status_i) state_d = SEQ_TIMING;
            SEQ_TIMING: if (cnt_q == CNT_LAST) state_d = is_status_q ? SEQ_RETIRE : SEQ_FLUSH;
            SEQ_FLUSH:  if (idx_q == IDX_LAST) state_d = SEQ_RETIRE;
            SEQ_RETIRE: state_d = SEQ_IDLE;
            default:    state_d = SEQ_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            idx_q       <= '0;
            is_status_q <= 1'b0;
            sr_data_q   <= '0;
            wel_q       <= 1'b0;
            sr_q        <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    cnt_q <= '0;
                    idx_q <= '0;
                    if (go_array_i || go_status_i) begin
                        is_status_q <= go_status_i;
                        sr_data_q   <= sr_data_i;
                    end
                    if (set_wel_i)      wel_q <= 1'b1;
                    else if (clr_wel_i) wel_q <= 1'b0;
                end
                SEQ_TIMING: cnt_q <= cnt_q + 1'b1;
                SEQ_FLUSH:  idx_q <= idx_q + 1'b1;
                SEQ_RETIRE: begin
                    wel_q <= 1'b0;
                    if (is_status_q) begin
                        sr_q.wpen <= sr_data_q[7];
                        sr_q.bp   <= sr_data_q[3:2];
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o   = (state_q != SEQ_IDLE);
        arr_we_o = (state_q == SEQ_FLUSH) && rd_valid_i;
        rd_idx_o = idx_q;
        wel_o    = wel_q;
        sr_o     = sr_q;
    end

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_TIMING) |-> (cnt_q < CNT_W'(WRITE_CYCLES))); // R7
    AST_SR_ONLY_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SEQ_RETIRE) |=> $stable(sr_o)); // R12
endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine
    import pce_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int PAGE_BYTES   = 32,
    parameter int WRITE_CYCLES = 2000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid_i,
    input  logic [7:0]        op_byte_i,
    input  logic              addr_valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_i,
    input  logic              cs_rise_i,
    input  logic              cs_aligned_i,
    input  logic              page_locked_i,
    input  logic              status_locked_i,
    output logic [ADDR_W-1:0] page_base_o,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [7:0]        arr_wdata_o,
    output logic              busy_o,
    output logic              wel_o,
    output logic [7:0]        status_o
);
    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int BASE_W = ADDR_W - OFS_W;

    logic              buf_load, buf_wr;
    logic              set_wel, clr_wel, go_array, go_status;
    logic [7:0]        sr_data;
    logic [OFS_W-1:0]  rd_idx;
    logic [7:0]        rd_data;
    logic              rd_valid;
    logic [BASE_W-1:0] base;
    sr_bits_t          sr;

    pce_capture u_capture (
        .clk             (clk),
        .rst_n           (rst_n),
        .op_valid_i      (op_valid_i),
        .op_byte_i       (op_byte_i),
        .addr_valid_i    (addr_valid_i),
        .byte_valid_i    (byte_valid_i),
        .byte_i          (byte_i),
        .cs_rise_i       (cs_rise_i),
        .cs_aligned_i    (cs_aligned_i),
        .busy_i          (busy_o),
        .wel_i           (wel_o),
        .page_locked_i   (page_locked_i),
        .status_locked_i (status_locked_i),
        .buf_load_o      (buf_load),
        .buf_wr_o        (buf_wr),
        .set_wel_o       (set_wel),
        .clr_wel_o       (clr_wel),
        .go_array_o      (go_array),
        .go_status_o     (go_status),
        .sr_data_o       (sr_data)
    );

    pce_page_buf #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (buf_load),
        .load_addr_i (addr_i),
        .wr_i        (buf_wr),
        .wr_data_i   (byte_i),
        .rd_idx_i    (rd_idx),
        .rd_data_o   (rd_data),
        .rd_valid_o  (rd_valid),
        .base_o      (base)
    );

    pce_sequencer #(.PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_wel_i   (set_wel),
        .clr_wel_i   (clr_wel),
        .go_array_i  (go_array),
        .go_status_i (go_status),
        .sr_data_i   (sr_data),
        .rd_valid_i  (rd_valid),
        .rd_idx_o    (rd_idx),
        .arr_we_o    (arr_we_o),
        .busy_o      (busy_o),
        .wel_o       (wel_o),
        .sr_o        (sr)
    );

    assign page_base_o = {base, {OFS_W{1'b0}}};
    assign arr_addr_o  = {base, rd_idx};
    assign arr_wdata_o = rd_data;
    assign status_o    = busy_o ? 8'hFF : {sr.wpen, 3'b000, sr.bp, wel_o, 1'b0};

    AST_BUSY_FROM_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(cs_rise_i)); // R7
    AST_WEL_CLEAR_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !wel_o); // R9
    AST_WEL_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(wel_o)); // R12
    AST_PAGE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(page_base_o)); // R6
endmodule

// File: tb/tb_page_commit_engine.sv
`timescale 1ns/1ps
module tb_page_commit_engine;
    localparam int ADDR_W = 13;
    localparam int WC     = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_valid_i = 1'b0;
    logic [7:0]        op_byte_i = '0;
    logic              addr_valid_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic              byte_valid_i = 1'b0;
    logic [7:0]        byte_i = '0;
    logic              cs_rise_i = 1'b0;
    logic              cs_aligned_i = 1'b0;
    logic              page_locked_i = 1'b0;
    logic              status_locked_i = 1'b0;
    logic [ADDR_W-1:0] page_base_o;
    logic              arr_we_o;
    logic [ADDR_W-1:0] arr_addr_o;
    logic [7:0]        arr_wdata_o;
    logic              busy_o;
    logic              wel_o;
    logic [7:0]        status_o;

    int checks = 0;
    int failures = 0;
    int run_len = 0;
    int last_run = 0;
    logic [ADDR_W+7:0] exp_q [$];

    always #2.5 clk = ~clk;

    page_commit_engine #(.ADDR_W(ADDR_W), .PAGE_BYTES(32), .WRITE_CYCLES(WC)) dut (.*);

    task automatic check_eq(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
        end
    endtask

    // monitor: pops expected array writes and tracks busy length
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_o) run_len++;
            else if (run_len != 0) begin
                last_run = run_len;
                run_len  = 0;
            end
            if (arr_we_o) begin
                check_eq("R7 write after timer", int'(run_len > WC), 1);
                if (exp_q.size() == 0) begin
                    check_eq("R6 unexpected write", int'({arr_addr_o, arr_wdata_o}), 0);
                end else begin
                    logic [ADDR_W+7:0] e;
                    e = exp_q.pop_front();
                    check_eq("R6 write addr/data", int'({arr_addr_o, arr_wdata_o}), int'(e));
                end
            end
        end
    end

    task automatic t_op(input logic [7:0] b);
        op_valid_i = 1'b1; op_byte_i = b;
        @(negedge clk); op_valid_i = 1'b0;
    endtask
    task automatic t_addr(input logic [ADDR_W-1:0] a);
        addr_valid_i = 1'b1; addr_i = a;
        @(negedge clk); addr_valid_i = 1'b0;
    endtask
    task automatic t_byte(input logic [7:0] b);
        byte_valid_i = 1'b1; byte_i = b;
        @(negedge clk); byte_valid_i = 1'b0;
    endtask
    task automatic t_cs(input logic aligned);
        cs_rise_i = 1'b1; cs_aligned_i = aligned;
        @(negedge clk); cs_rise_i = 1'b0; cs_aligned_i = 1'b0;
        @(negedge clk);
    endtask
    task automatic push_exp(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        exp_q.push_back({a, d});
    endtask
    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy_o; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 busy", busy_o, 0);
        check_eq("R1 wel", wel_o, 0);
        check_eq("R1 status", status_o, 8'h00);
        check_eq("R1 we", arr_we_o, 0);

        // R4 write without latch
        t_op(8'h02); t_addr(13'h0040); t_byte(8'h11); t_cs(1'b1);
        repeat (3) @(negedge clk);
        check_eq("R4 no busy without latch", busy_o, 0);

        // R3 latch opcode followed by more clocking
        t_op(8'h06); t_byte(8'h00); t_cs(1'b1);
        check_eq("R3 wel unchanged", wel_o, 0);

        // R2 set then clear then set
        t_op(8'h06); t_cs(1'b1);
        check_eq("R2 wel set", wel_o, 1);
        check_eq("R8 status latch bit", status_o, 8'h02);
        t_op(8'h04); t_cs(1'b1);
        check_eq("R2 wel clear", wel_o, 0);
        t_op(8'h06); t_cs(1'b1);

        // R5 misaligned release
        t_op(8'h02); t_addr(13'h0100); t_byte(8'h22); t_cs(1'b0);
        repeat (3) @(negedge clk);
        check_eq("R5 misaligned no busy", busy_o, 0);
        check_eq("R5 latch kept", wel_o, 1);

        // R5 no data byte
        t_op(8'h02); t_addr(13'h0100); t_cs(1'b1);
        repeat (3) @(negedge clk);
        check_eq("R5 no data no busy", busy_o, 0);

        // R11 locked page
        page_locked_i = 1'b1;
        t_op(8'h02); t_addr(13'h1F00); t_byte(8'h33); t_cs(1'b1);
        page_locked_i = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R11 locked no busy", busy_o, 0);
        check_eq("R11 latch kept", wel_o, 1);

        // single byte write, with a status write attempted while busy
        push_exp(13'h0123, 8'hA5);
        t_op(8'h02); t_addr(13'h0123); t_byte(8'hA5); t_cs(1'b1);
        check_eq("R7 busy after release", busy_o, 1);
        check_eq("R8 status while busy", status_o, 8'hFF);
        t_op(8'h01); t_byte(8'hFF); t_cs(1'b1);   // R12 ignored
        wait_idle();
        check_eq("R7 array busy length", last_run, WC + 33);
        check_eq("R6 all writes seen", exp_q.size(), 0);
        check_eq("R9 latch cleared", wel_o, 0);
        check_eq("R12 status untouched", status_o, 8'h00);
        repeat (3) @(negedge clk);
        check_eq("R12 no second cycle", busy_o, 0);

        // R6 page wrap: start at offset 30, 34 bytes
        for (int o = 0; o < 32; o++) begin
            logic [7:0] d;
            d = (o < 30) ? 8'(8'h40 + o + 2) : 8'(8'h40 + 32 + (o - 30));
            push_exp(13'h0A20 + 13'(o), d);
        end
        t_op(8'h06); t_cs(1'b1);
        t_op(8'h02); t_addr(13'h0A3E);
        for (int i = 0; i < 34; i++) t_byte(8'(8'h40 + i));
        check_eq("R6 page base out", page_base_o, 13'h0A20);
        t_cs(1'b1);
        wait_idle();
        check_eq("R6 wrap writes seen", exp_q.size(), 0);
        check_eq("R9 latch cleared page", wel_o, 0);

        // R11 status write blocked
        t_op(8'h06); t_cs(1'b1);
        status_locked_i = 1'b1;
        t_op(8'h01); t_byte(8'hFF); t_cs(1'b1);
        status_locked_i = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R11 status blocked", busy_o, 0);
        check_eq("R11 status latch kept", status_o, 8'h02);

        // R10 status write: first byte only, bits 7,3,2
        t_op(8'h01); t_byte(8'hFF); t_byte(8'h00); t_cs(1'b1);
        wait_idle();
        check_eq("R7 status busy length", last_run, WC + 1);
        check_eq("R10 status bits", status_o, 8'h8C);
        check_eq("R9 latch cleared status", wel_o, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule